// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits on the processor side of a shared address/data bus and runs one read or write transfer per request. A request carries an address, a direction, a memory-or-I/O flag, two byte enables and the write data. The sequencer steps through four base clock states (T1 to T4). In T1 it pulses an address strobe with the address on the shared bus. In T2 it turns the bus around and asserts an active-low read or write strobe. It adds wait states after T3 for as long as the addressed device holds `ready_i` low. In T4 it releases the strobes and pulses `done_o` with the captured read data.

The shared bus is modelled as a split pair: `bus_o` with its output enable `bus_oe_o`, and `bus_i` for the data the device returns. A pad ring or a bidirectional buffer outside the block joins them. Byte selection uses the usual pairing of an active-low high-byte enable with address bit 0.

Top module: `bus_cycle_seq`

## Requirements
- R1: Every bus cycle starts with one T1 cycle in which `ale_o` is 1 for exactly one clock, `bus_oe_o` is 1 and `bus_o` carries the request address, with bit 0 replaced as in R3.
- R2: `mio_o` equals the request's memory flag (1 = memory, 0 = I/O) from T1 through T4 and does not change inside a cycle.
- R3: `bus_o[0]` in T1 is the inverse of `req_be_i[0]`, and `bhe_no` is the inverse of `req_be_i[1]` from T1 through T4 (11 = word, 01 = low byte, 10 = high byte). A request with `req_be_i` = 00 is never accepted and starts no cycle.
- R4: For a read, `bus_oe_o` is 0 and `rd_no` is 0 from T2 until T4; `wr_no` stays 1.
- R5: For a write, `bus_oe_o` is 1 with the write data zero-extended on `bus_o`, and `wr_no` is 0, from T2 until T4; `rd_no` stays 1.
- R6: Read data is taken from `bus_i` at the clock edge that ends the last T3 or wait state, and it is presented on `rdata_o` while `done_o` is 1. Write cycles leave `rdata_o` unchanged.
- R7: When `ready_i` is 0 at the end of T3 or of a wait state, another wait state follows. The strobe is therefore low for 2 + N cycles, where N is the number of end-of-T3/wait edges that see `ready_i` at 0.
- R8: In T4, `rd_no` and `wr_no` are 1, `bus_oe_o` is 0 and `done_o` is 1 for exactly that one cycle.
- R9: `req_ready_o` is 1 only in the idle state and in T4. A request is accepted only then, and one accepted in T4 starts T1 in the very next cycle. A request held while a cycle runs is not taken until then.
- R10: While `rst_ni` is low the block is idle: `ale_o` = 0, `rd_no` = `wr_no` = `bhe_no` = 1, `bus_oe_o` = 0, `done_o` = 0, `req_ready_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr_i | input | ADDR_W | Request address |
| req_be_i | input | 2 | Byte enables, bit 1 high byte, bit 0 low byte |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| ale_o | output | 1 | Address latch strobe |
| mio_o | output | 1 | Memory/IO indicator |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| bhe_no | output | 1 | High-byte enable, active low |
| bus_o | output | ADDR_W | Shared bus output value |
| bus_oe_o | output | 1 | Shared bus output enable |
| bus_i | input | DATA_W | Shared bus input value |
| ready_i | input | 1 | Device ready |
| done_o | output | 1 | Cycle complete pulse |
| rdata_o | output | DATA_W | Captured read data |

## Verification
The bound checker watches the port-level rules on every clock: the address strobe lasts one cycle and is followed by a strobe, the two strobes never overlap, the bus is released under a read strobe and driven under a write strobe, the space indicator holds still while a strobe is low, a low ready keeps the strobe low, and the done pulse only comes with both strobes released. Only the bench's scenarios show that the address, byte lane encoding and write data on the bus match the request, that the strobe width grows by exactly one cycle per wait, that read data is taken at the right edge, that zero-enable requests are dropped and that a back-to-back request starts T1 straight after T4.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_be_i,
  input  logic       ready_i,
  output bus_state_e state_o,
  output logic       accept_o,
  output logic       open_o
);
  bus_state_e state_q, state_d;

  assign open_o   = (state_q == ST_IDLE) || (state_q == ST_T4);
  // zero byte enables never start a cycle
  assign accept_o = open_o && req_valid_i && (|req_be_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_TW:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:   state_d = accept_o ? ST_T1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bus_seq_req.sv
module bus_seq_req #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              req_write_i,
  input  logic              req_mem_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              write_o,
  output logic              mem_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bhe_n_o,
  output logic [ADDR_W-1:0] wdata_o
);
  logic [ADDR_W-1:0] wdata_ext;

  generate
    if (DATA_W == ADDR_W) begin : g_same
      assign wdata_ext = req_wdata_i;
    end else begin : g_ext
      assign wdata_ext = {{(ADDR_W-DATA_W){1'b0}}, req_wdata_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o <= 1'b0;
      mem_o   <= 1'b0;
      addr_o  <= '0;
      bhe_n_o <= 1'b1;
      wdata_o <= '0;
    end else if (accept_i) begin
      write_o <= req_write_i;
      mem_o   <= req_mem_i;
      // low-lane select travels on address bit 0, active low
      addr_o  <= {req_addr_i[ADDR_W-1:1], ~req_be_i[0]};
      bhe_n_o <= ~req_be_i[1];
      wdata_o <= wdata_ext;
    end
  end
endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  bus_state_e        state_i,
  input  logic              open_i,
  input  logic              write_i,
  input  logic              mem_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bhe_n_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic              req_ready_o,
  output logic              ale_o,
  output logic              mio_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              bhe_no,
  output logic [ADDR_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              done_o
);
  logic in_cycle, strobe_ph;

  assign in_cycle  = (state_i != ST_IDLE);
  assign strobe_ph = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);

  always_comb begin
    req_ready_o = open_i;
    ale_o       = (state_i == ST_T1);
    mio_o       = in_cycle ? mem_i : 1'b0;
    bhe_no      = in_cycle ? bhe_n_i : 1'b1;
    rd_no       = !(strobe_ph && !write_i);
    wr_no       = !(strobe_ph && write_i);
    done_o      = (state_i == ST_T4);
    bus_oe_o    = 1'b0;
    bus_o       = '0;
    if (state_i == ST_T1) begin
      bus_oe_o = 1'b1;
      bus_o    = addr_i;
    end else if (strobe_ph && write_i) begin
      bus_oe_o = 1'b1;
      bus_o    = wdata_i;
    end
  end
endmodule

// File: rtl/bus_seq_rdcap.sv
module bus_seq_rdcap
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_state_e        state_i,
  input  logic              write_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic take;

  // sample on the edge that leaves the last T3/Tw
  assign take = ((state_i == ST_T3) || (state_i == ST_TW)) && ready_i && !write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (take) rdata_o <= bus_i;
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_mem_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              ale_o,
  output logic              mio_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              bhe_no,
  output logic [ADDR_W-1:0] bus_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              ready_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  bus_state_e        state;
  logic              accept, open_ph;
  logic              l_write, l_mem, l_bhe_n;
  logic [ADDR_W-1:0] l_addr, l_wdata;

  bus_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_be_i    (req_be_i),
    .ready_i     (ready_i),
    .state_o     (state),
    .accept_o    (accept),
    .open_o      (open_ph)
  );

  bus_seq_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .req_write_i (req_write_i),
    .req_mem_i   (req_mem_i),
    .req_addr_i  (req_addr_i),
    .req_be_i    (req_be_i),
    .req_wdata_i (req_wdata_i),
    .write_o     (l_write),
    .mem_o       (l_mem),
    .addr_o      (l_addr),
    .bhe_n_o     (l_bhe_n),
    .wdata_o     (l_wdata)
  );

  bus_seq_drive #(.ADDR_W(ADDR_W)) u_drive (
    .state_i     (state),
    .open_i      (open_ph),
    .write_i     (l_write),
    .mem_i       (l_mem),
    .addr_i      (l_addr),
    .bhe_n_i     (l_bhe_n),
    .wdata_i     (l_wdata),
    .req_ready_o (req_ready_o),
    .ale_o       (ale_o),
    .mio_o       (mio_o),
    .rd_no       (rd_no),
    .wr_no       (wr_no),
    .bhe_no      (bhe_no),
    .bus_o       (bus_o),
    .bus_oe_o    (bus_oe_o),
    .done_o      (done_o)
  );

  bus_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .write_i (l_write),
    .ready_i (ready_i),
    .bus_i   (bus_i),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ale_o,
  input logic mio_o,
  input logic rd_no,
  input logic wr_no,
  input logic bus_oe_o,
  input logic ready_i,
  input logic done_o,
  input logic req_ready_o
);
  AST_ALE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);                                                    // R1
  AST_ALE_THEN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!rd_no || !wr_no));                                        // R1
  AST_MIO_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> $stable(mio_o));                               // R2
  AST_RD_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !bus_oe_o);                                                // R4
  AST_WR_BUS_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> bus_oe_o);                                                 // R5
  AST_NO_DUAL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));                                                 // R4
  AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rd_no || !wr_no) && !ready_i) |=> (!rd_no || !wr_no));             // R7
  AST_DONE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_no && wr_no && !bus_oe_o));                            // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                                  // R8
  AST_BUSY_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no || ale_o) |-> !req_ready_o);                        // R9
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ale_o       (ale_o),
  .mio_o       (mio_o),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .bus_oe_o    (bus_oe_o),
  .ready_i     (ready_i),
  .done_o      (done_o),
  .req_ready_o (req_ready_o)
);

// File: tb/bus_cycle_seq_tb.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct {
    logic          write;
    logic          mem;
    logic [AW-1:0] addr;
    logic [1:0]    be;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    int            waits;
  } item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0, req_mem_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_be_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          req_ready_o, ale_o, mio_o, rd_no, wr_no, bhe_no, bus_oe_o, done_o;
  logic [AW-1:0] bus_o;
  logic [DW-1:0] bus_i = '0;
  logic          ready_i = 1'b0;
  logic [DW-1:0] rdata_o;

  always #2.5 clk_i = ~clk_i;

  bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_mem_i(req_mem_i), .req_addr_i(req_addr_i), .req_be_i(req_be_i),
    .req_wdata_i(req_wdata_i), .req_ready_o(req_ready_o), .ale_o(ale_o), .mio_o(mio_o),
    .rd_no(rd_no), .wr_no(wr_no), .bhe_no(bhe_no), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .bus_i(bus_i), .ready_i(ready_i), .done_o(done_o), .rdata_o(rdata_o)
  );

  int n_checks = 0, n_err = 0;
  item_t exp_q[$];
  logic [DW-1:0] last_rdata = '0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  // device model: ready after 2+waits strobe cycles, returns read data
  int dcnt = 0;
  always @(negedge clk_i) begin
    if (rst_ni && (!rd_no || !wr_no) && exp_q.size() > 0) begin
      dcnt++;
      ready_i <= (dcnt >= 2 + exp_q[0].waits);
      bus_i   <= rd_no ? '0 : exp_q[0].rdata;
    end else begin
      dcnt = 0;
      ready_i <= 1'b0;
      bus_i   <= '0;
    end
  end

  // monitor / scoreboard
  logic [AW-1:0] m_addr, m_wdata;
  logic m_mio, m_bhe, m_rd, m_wr, m_oe_bad, m_mio_bad, m_ale_oe;
  int m_str = 0, gap = 0, last_gap = -1;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ale_o) begin
        m_addr = bus_o; m_mio = mio_o; m_bhe = bhe_no; m_ale_oe = bus_oe_o;
        m_str = 0; m_rd = 0; m_wr = 0; m_oe_bad = 0; m_mio_bad = 0; m_wdata = '0;
        last_gap = gap;
      end
      if (!rd_no || !wr_no) begin
        m_str++;
        if (mio_o != m_mio || bhe_no != m_bhe) m_mio_bad = 1;
        if (!rd_no) begin m_rd = 1; if (bus_oe_o) m_oe_bad = 1; end
        if (!wr_no) begin m_wr = 1; m_wdata = bus_o; if (!bus_oe_o) m_oe_bad = 1; end
      end
      if (done_o) begin
        gap = 0;
        if (exp_q.size() == 0) chk(0, "R9 unexpected done", 1, 0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          chk(m_addr == {it.addr[AW-1:1], ~it.be[0]}, "R1/R3 address", m_addr, {it.addr[AW-1:1], ~it.be[0]});
          chk(m_ale_oe, "R1 oe in T1", m_ale_oe, 1);
          chk(m_mio == it.mem && mio_o == it.mem && !m_mio_bad, "R2 mio", m_mio, it.mem);
          chk(m_bhe == ~it.be[1], "R3 bhe", m_bhe, ~it.be[1]);
          chk(m_str == 2 + it.waits, "R7 strobe width", m_str, 2 + it.waits);
          chk(rd_no && wr_no && !bus_oe_o, "R8 T4 release", {rd_no, wr_no, bus_oe_o}, 3'b110);
          chk(!m_oe_bad, "R4/R5 bus direction", m_oe_bad, 0);
          if (it.write) begin
            chk(m_wr && !m_rd, "R5 write strobe", {m_wr, m_rd}, 2'b10);
            chk(m_wdata == AW'(it.wdata), "R5 write data", m_wdata, it.wdata);
            chk(rdata_o == last_rdata, "R6 rdata kept on write", rdata_o, last_rdata);
          end else begin
            chk(m_rd && !m_wr, "R4 read strobe", {m_wr, m_rd}, 2'b01);
            chk(rdata_o == it.rdata, "R6 read data", rdata_o, it.rdata);
            last_rdata = it.rdata;
          end
        end
      end else gap++;
    end
  end

  // driver: called at a negedge
  task automatic send(input logic wr, input logic mem, input logic [AW-1:0] a,
                      input logic [1:0] be, input logic [DW-1:0] wd,
                      input logic [DW-1:0] rd, input int waits);
    item_t it;
    req_valid_i = 1; req_write_i = wr; req_mem_i = mem;
    req_addr_i = a; req_be_i = be; req_wdata_i = wd;
    while (!req_ready_o) @(negedge clk_i);
    it.write = wr; it.mem = mem; it.addr = a; it.be = be;
    it.wdata = wd; it.rdata = rd; it.waits = waits;
    exp_q.push_back(it);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(!ale_o && rd_no && wr_no && bhe_no, "R10 strobes idle", {ale_o, rd_no, wr_no, bhe_no}, 4'b0111);
    chk(!bus_oe_o && !done_o && req_ready_o, "R10 bus and flags", {bus_oe_o, done_o, req_ready_o}, 3'b001);
    rst_ni = 1;
    @(negedge clk_i);

    send(0, 1, 20'h12344, 2'b11, 16'h0, 16'hBEEF, 0);   // R4 word read, no wait
    drain();
    send(1, 0, 20'h00740, 2'b01, 16'h00A5, 16'h0, 1);   // R5 low byte I/O write, one wait
    drain();
    send(0, 0, 20'h00741, 2'b10, 16'h0, 16'h5A00, 3);   // R7 high byte read, three waits
    drain();

    // R3 zero byte enables are never accepted
    req_valid_i = 1; req_write_i = 0; req_mem_i = 1; req_addr_i = 20'h0ABC0; req_be_i = 2'b00;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(!ale_o && rd_no && req_ready_o, "R3 zero enables ignored", {ale_o, rd_no, req_ready_o}, 3'b011);
    end
    req_valid_i = 0;
    @(negedge clk_i);

    // R9 back-to-back: second request held during the first, starts right after T4
    send(1, 1, 20'hF0002, 2'b11, 16'h1234, 16'h0, 2);
    send(0, 1, 20'hF0004, 2'b11, 16'h0, 16'hC3C3, 0);
    drain();
    chk(last_gap == 0, "R9 back-to-back T1 after T4", last_gap, 0);

    send(0, 1, 20'h00010, 2'b01, 16'h0, 16'h0077, 1);   // R6 read after idle
    drain();
    chk(last_gap > 0, "R9 idle gap before isolated cycle", last_gap, 1);
    chk(req_ready_o && !done_o, "R9 back to idle", {req_ready_o, done_o}, 2'b10);

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule